// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This block keeps the stack pointer of a 16-bit machine together with a small byte-addressed stack memory. The stack grows toward lower addresses, and the pointer always names the item pushed most recently, which is also the item the next pop returns. A push moves the pointer down by one word (two bytes) and then writes at the new address. A pop reads at the current address and then moves the pointer up by one word. Read data comes back one cycle after the request, with a one-cycle valid strobe.

Software can also load the pointer directly. The pointer has no storage for bit 0, so it is always even. A load with an odd value stores the value with bit 0 cleared and sets a sticky error flag. A separate clear input resets the flag. A byte-sized push writes only the low byte lane of the addressed word, but the pointer still moves by a full word. The memory is a word array indexed by the low pointer bits, so addresses wrap modulo its size.

Top module: `dstack_unit`

## Requirements
- R1: After reset, sp_out equals the TOP_ADDR parameter (default 16'h0400), err_out is 0 and pop_valid is 0.
- R2: Pops return items in the reverse order of their pushes (last in, first out).
- R3: An accepted push sets sp_out to the old value minus 2 and writes the data at that new address.
- R4: An accepted pop reads the word at the current sp_out. In the next cycle pop_data holds that word, pop_valid is 1 for exactly that one cycle, and sp_out has increased by 2.
- R5: Bit 0 of sp_out is always 0.
- R6: A load (ld_en=1) stores ld_value with bit 0 forced to 0. If ld_value bit 0 is 1, err_out becomes 1 in the next cycle. An even value leaves err_out unchanged.
- R7: err_out stays 1 until err_clr is asserted. If an odd load and err_clr occur in the same cycle, the error flag is set.
- R8: A push with byte_mode=1 writes only bits 7:0 of the addressed word. Bits 15:8 keep their previous contents, and sp_out still moves down by 2.
- R9: A pop with byte_mode=1 returns {8'h00, bits 7:0 of the word}, and sp_out moves up by 2.
- R10: A pop does not erase the word. If the pointer is later loaded back to that address, a pop returns the same word again.
- R11: At most one operation is accepted per cycle, with priority load > push > pop. An operation that loses has no effect on sp_out, on memory or on pop_valid.
- R12: Pointer arithmetic wraps modulo 2^ADDR_W, so a push with sp_out=16'h0000 gives 16'hFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| byte_mode | input | 1 | 1: byte-sized operation, 0: word-sized operation |
| push_data | input | 16 | Data to push |
| pop_data | output | 16 | Popped data, valid when pop_valid is 1 |
| pop_valid | output | 1 | One-cycle strobe, one cycle after an accepted pop |
| ld_en | input | 1 | Pointer load strobe |
| ld_value | input | 16 | Value to load into the pointer |
| err_clr | input | 1 | Clears the error flag |
| sp_out | output | 16 | Current stack pointer |
| err_out | output | 1 | Sticky odd-load error flag |

## Verification
A wrong pointer value shows on sp_out in the cycle after the faulty operation. The same fault also shows later, as wrong pop_data: a pop reads a word other than the one that should be on top of the stack. A write to the wrong address or to the wrong byte lane is only visible when that word is popped. For this reason every push in the stimulus is later undone by a pop, and byte writes are checked against a word of known prior contents. The sticky error flag and the wrap-around of the pointer are checked in the cycle right after the load or push that affects them.

// File: rtl/dstack_pkg.sv
package dstack_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_LOAD = 2'd1,
      OP_PUSH = 2'd2,
      OP_POP  = 2'd3
   } stk_op_e;

endpackage

// File: rtl/dstack_arb.sv
module dstack_arb
   import dstack_pkg::*;
(
   input  logic    push_req,
   input  logic    pop_req,
   input  logic    ld_en,
   output stk_op_e op
);
   // One operation per cycle: load, then push, then pop.
   always_comb begin
      if (ld_en)         op = OP_LOAD;
      else if (push_req) op = OP_PUSH;
      else if (pop_req)  op = OP_POP;
      else               op = OP_IDLE;
   end
endmodule

// File: rtl/dstack_ptr.sv
module dstack_ptr
   import dstack_pkg::*;
#(
   parameter int unsigned           ADDR_W   = 16,
   parameter int unsigned           STEP     = 2,
   parameter logic [ADDR_W-1:0]     TOP_ADDR = 'h0400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  stk_op_e           op,
   input  logic [ADDR_W-1:0] ld_value,
   input  logic              err_clr,
   output logic [ADDR_W-1:0] sp,
   output logic [ADDR_W-1:0] sp_dec,
   output logic              err
);
   // Bit 0 has no storage: the pointer is even by construction.
   logic [ADDR_W-1:1] sp_hi;
   logic [ADDR_W-1:0] sp_inc;

   assign sp     = {sp_hi, 1'b0};
   assign sp_dec = sp - ADDR_W'(STEP);
   assign sp_inc = sp + ADDR_W'(STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_hi <= TOP_ADDR[ADDR_W-1:1];
      end else begin
         unique case (op)
            OP_LOAD: sp_hi <= ld_value[ADDR_W-1:1];
            OP_PUSH: sp_hi <= sp_dec[ADDR_W-1:1];
            OP_POP:  sp_hi <= sp_inc[ADDR_W-1:1];
            default: sp_hi <= sp_hi;
         endcase
      end
   end

   // Sticky odd-load flag; setting wins over clearing.
   always_ff @(posedge clk) begin
      if (!rst_n)                           err <= 1'b0;
      else if (op == OP_LOAD && ld_value[0]) err <= 1'b1;
      else if (err_clr)                     err <= 1'b0;
   end
endmodule

// File: rtl/dstack_mem.sv
module dstack_mem #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned MEM_WORDS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_byte,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              rd_byte,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned SHIFT = $clog2(LANES);
   localparam int unsigned IDX_W = $clog2(MEM_WORDS);

   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [DATA_W-1:0] rd_word;
   logic              byte_q;

   assign wr_idx = wr_addr[IDX_W+SHIFT-1:SHIFT];
   assign rd_idx = rd_addr[IDX_W+SHIFT-1:SHIFT];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] lane_mem [MEM_WORDS];
      logic [7:0] lane_q;
      // A byte push touches lane 0 only.
      logic       lane_we;
      assign lane_we = wr_en && ((l == 0) || !wr_byte);

      always_ff @(posedge clk) begin
         if (lane_we) lane_mem[wr_idx] <= wr_data[l*8 +: 8];
      end
      always_ff @(posedge clk) begin
         if (rd_en) lane_q <= lane_mem[rd_idx];
      end
      assign rd_word[l*8 +: 8] = lane_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         byte_q   <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) byte_q <= rd_byte;
      end
   end

   assign rd_data = byte_q ? {{(DATA_W-8){1'b0}}, rd_word[7:0]} : rd_word;
endmodule

// File: rtl/dstack_unit.sv
module dstack_unit
   import dstack_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       DATA_W    = 16,
   parameter int unsigned       MEM_WORDS = 32,
   parameter logic [ADDR_W-1:0] TOP_ADDR  = 'h0400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic              byte_mode,
   input  logic [DATA_W-1:0] push_data,
   output logic [DATA_W-1:0] pop_data,
   output logic              pop_valid,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_value,
   input  logic              err_clr,
   output logic [ADDR_W-1:0] sp_out,
   output logic              err_out
);
   localparam int unsigned STEP = DATA_W / 8;

   if (DATA_W != 16) begin : g_bad_width
      initial $fatal(1, "dstack_unit: DATA_W must be 16");
   end
   if (TOP_ADDR[0] != 1'b0) begin : g_bad_top
      initial $fatal(1, "dstack_unit: TOP_ADDR must be even");
   end
   if ((MEM_WORDS < 2) || ((MEM_WORDS & (MEM_WORDS - 1)) != 0)) begin : g_bad_depth
      initial $fatal(1, "dstack_unit: MEM_WORDS must be a power of two");
   end
   if (ADDR_W < $clog2(MEM_WORDS) + 1) begin : g_bad_addr
      initial $fatal(1, "dstack_unit: ADDR_W too small for MEM_WORDS");
   end

   stk_op_e           op;
   logic [ADDR_W-1:0] sp, sp_dec;

   dstack_arb u_arb (
      .push_req (push_req),
      .pop_req  (pop_req),
      .ld_en    (ld_en),
      .op       (op)
   );

   dstack_ptr #(
      .ADDR_W   (ADDR_W),
      .STEP     (STEP),
      .TOP_ADDR (TOP_ADDR)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .ld_value (ld_value),
      .err_clr  (err_clr),
      .sp       (sp),
      .sp_dec   (sp_dec),
      .err      (err_out)
   );

   dstack_mem #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .MEM_WORDS (MEM_WORDS)
   ) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (op == OP_PUSH),
      .wr_byte  (byte_mode),
      .wr_addr  (sp_dec),
      .wr_data  (push_data),
      .rd_en    (op == OP_POP),
      .rd_byte  (byte_mode),
      .rd_addr  (sp),
      .rd_data  (pop_data),
      .rd_valid (pop_valid)
   );

   assign sp_out = sp;
endmodule

// File: rtl/dstack_unit_chk.sv
module dstack_unit_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_req,
   input logic              pop_req,
   input logic              ld_en,
   input logic [ADDR_W-1:0] ld_value,
   input logic              err_clr,
   input logic [ADDR_W-1:0] sp_out,
   input logic              err_out,
   input logic              pop_valid
);
   logic pop_take;
   assign pop_take = pop_req && !push_req && !ld_en;

   always @(posedge clk) if (rst_n) AST_SP_EVEN: assert (sp_out[0] == 1'b0); // R5

   AST_PUSH_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && !ld_en) |=> (sp_out == $past(sp_out) - ADDR_W'(2))); // R3

   AST_POP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      pop_take |=> (sp_out == $past(sp_out) + ADDR_W'(2))); // R4

   AST_POP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      pop_take |=> pop_valid); // R4

   AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_take |=> !pop_valid); // R11

   AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (sp_out == {$past(ld_value[ADDR_W-1:1]), 1'b0})); // R6

   AST_ODD_LOAD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_value[0]) |=> err_out); // R6

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_out && !err_clr) |=> err_out); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_req && !pop_req && !ld_en) |=> $stable(sp_out)); // R11
endmodule

bind dstack_unit dstack_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .push_req  (push_req),
   .pop_req   (pop_req),
   .ld_en     (ld_en),
   .ld_value  (ld_value),
   .err_clr   (err_clr),
   .sp_out    (sp_out),
   .err_out   (err_out),
   .pop_valid (pop_valid)
);

// File: tb/dstack_unit_test.sv
module dstack_unit_test;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [23:0] tag;
      logic        push, pop, bmode, ld, clr;
      logic [15:0] data, ldv, esp;
      logic        evld;
      logic [15:0] epd;
      logic        eerr;
   } vec_t;

   function automatic vec_t mk(logic [23:0] tag, logic push, logic pop, logic bmode,
                               logic ld, logic clr, logic [15:0] data, logic [15:0] ldv,
                               logic [15:0] esp, logic evld, logic [15:0] epd, logic eerr);
      return '{tag, push, pop, bmode, ld, clr, data, ldv, esp, evld, epd, eerr};
   endfunction

   localparam int NV = 22;
   //                           tag    pu   po   by   ld   cl   data      ldv       sp        vld  pdata     err
   localparam vec_t VEC [NV] = '{
      mk("R3 ", 1'b1,1'b0,1'b0,1'b0,1'b0,16'h1111,16'h0000,16'h03FE,1'b0,16'h0000,1'b0),
      mk("R3 ", 1'b1,1'b0,1'b0,1'b0,1'b0,16'h2222,16'h0000,16'h03FC,1'b0,16'h0000,1'b0),
      mk("R3 ", 1'b1,1'b0,1'b0,1'b0,1'b0,16'h3333,16'h0000,16'h03FA,1'b0,16'h0000,1'b0),
      mk("R4 ", 1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h03FC,1'b1,16'h3333,1'b0),
      mk("R2 ", 1'b1,1'b0,1'b0,1'b0,1'b0,16'h4444,16'h0000,16'h03FA,1'b0,16'h0000,1'b0),
      mk("R2 ", 1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h03FC,1'b1,16'h4444,1'b0),
      mk("R2 ", 1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h03FE,1'b1,16'h2222,1'b0),
      mk("R8 ", 1'b1,1'b0,1'b1,1'b0,1'b0,16'hAB55,16'h0000,16'h03FC,1'b0,16'h0000,1'b0),
      mk("R8 ", 1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h03FE,1'b1,16'h2255,1'b0),
      mk("R9 ", 1'b0,1'b1,1'b1,1'b0,1'b0,16'h0000,16'h0000,16'h0400,1'b1,16'h0011,1'b0),
      mk("R6 ", 1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,16'h03FB,16'h03FA,1'b0,16'h0000,1'b1),
      mk("R7 ", 1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h03FA,1'b0,16'h0000,1'b1),
      mk("R10", 1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h03FC,1'b1,16'h4444,1'b1),
      mk("R7 ", 1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h0000,16'h03FC,1'b0,16'h0000,1'b0),
      mk("R6 ", 1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,16'h0000,16'h0000,1'b0,16'h0000,1'b0),
      mk("R12", 1'b1,1'b0,1'b0,1'b0,1'b0,16'h5A5A,16'h0000,16'hFFFE,1'b0,16'h0000,1'b0),
      mk("R12", 1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h0000,1'b1,16'h5A5A,1'b0),
      mk("R11", 1'b1,1'b1,1'b0,1'b0,1'b0,16'h7777,16'h0000,16'hFFFE,1'b0,16'h0000,1'b0),
      mk("R11", 1'b1,1'b0,1'b0,1'b1,1'b0,16'h9999,16'hFFFE,16'hFFFE,1'b0,16'h0000,1'b0),
      mk("R11", 1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h0000,1'b1,16'h7777,1'b0),
      mk("R7 ", 1'b0,1'b0,1'b0,1'b1,1'b1,16'h0000,16'h0105,16'h0104,1'b0,16'h0000,1'b1),
      mk("R7 ", 1'b0,1'b0,1'b0,1'b0,1'b1,16'h0000,16'h0000,16'h0104,1'b0,16'h0000,1'b0)
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        push_req, pop_req, byte_mode, ld_en, err_clr;
   logic [15:0] push_data, ld_value, pop_data, sp_out;
   logic        pop_valid, err_out;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dstack_unit uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (push_req),
      .pop_req   (pop_req),
      .byte_mode (byte_mode),
      .push_data (push_data),
      .pop_data  (pop_data),
      .pop_valid (pop_valid),
      .ld_en     (ld_en),
      .ld_value  (ld_value),
      .err_clr   (err_clr),
      .sp_out    (sp_out),
      .err_out   (err_out)
   );

   task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      push_req = 0; pop_req = 0; byte_mode = 0; ld_en = 0; err_clr = 0;
      push_data = '0; ld_value = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1", "sp_out", sp_out, 16'h0400);
      check("R1", "err_out", {15'd0, err_out}, 16'd0);
      check("R1", "pop_valid", {15'd0, pop_valid}, 16'd0);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         push_req = VEC[i].push; pop_req = VEC[i].pop; byte_mode = VEC[i].bmode;
         ld_en = VEC[i].ld; err_clr = VEC[i].clr;
         push_data = VEC[i].data; ld_value = VEC[i].ldv;
         @(posedge clk);
         #1;
         check($sformatf("%s", VEC[i].tag), "sp_out", sp_out, VEC[i].esp);
         check("R5", "sp_out bit0", {15'd0, sp_out[0]}, 16'd0);
         check($sformatf("%s", VEC[i].tag), "err_out", {15'd0, err_out}, {15'd0, VEC[i].eerr});
         check($sformatf("%s", VEC[i].tag), "pop_valid", {15'd0, pop_valid}, {15'd0, VEC[i].evld});
         if (VEC[i].evld)
            check($sformatf("%s", VEC[i].tag), "pop_data", pop_data, VEC[i].epd);
      end

      // R4: strobe lasts one cycle only
      @(negedge clk) idle_inputs();
      @(negedge clk) pop_req = 1;
      @(posedge clk); #1;
      check("R4", "pop_valid on", {15'd0, pop_valid}, 16'd1);
      @(negedge clk) idle_inputs();
      @(posedge clk); #1;
      check("R4", "pop_valid off", {15'd0, pop_valid}, 16'd0);

      // R1: reset in mid-run restores the top address and clears the flag
      @(negedge clk) begin ld_en = 1; ld_value = 16'h0033; end
      @(negedge clk) begin idle_inputs(); push_req = 1; push_data = 16'hBEEF; end
      @(negedge clk) begin idle_inputs(); rst_n = 0; end
      @(posedge clk); #1;
      check("R1", "sp_out after reset", sp_out, 16'h0400);
      check("R1", "err_out after reset", {15'd0, err_out}, 16'd0);
      @(negedge clk) rst_n = 1;
      @(posedge clk); #1;
      check("R1", "sp_out held idle", sp_out, 16'h0400);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule